// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry

This block is the shift and rotate stage of an integer datapath. Each cycle it may accept one operation. An operation carries an operand, an operation code, a size select for 8, 16 or 32 bits, a 5-bit count and the current carry, sign and zero flags. One clock later it returns the result, zero-extended to 32 bits, together with updated flags.

There are seven operations. Logical left shift has two codes. The others are logical right shift, arithmetic right shift, the two plain rotates, and the two rotates that pass through the carry. The carry flag takes the bit that last left the operand. For the rotates through carry, the carry is one more bit of a ring that is one bit wider than the operand. A count of zero is a no-op for the result and for all three flags. Shifts recompute sign and zero from their result. Rotates keep the sign and zero flags they were given.

Top module: `shrot_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. The result and flag outputs change only in the cycle after an accepted operation and hold their values while no operation is accepted.
- R2: Op codes 0 and 7 are the same left shift. Vacated low bits are zero. CF is operand bit W-n when the count n is at most W, and 0 when n is greater than W.
- R3: Op code 1 is a logical right shift with zero fill. CF is operand bit n-1 for n at most W, and 0 for larger n.
- R4: Op code 2 is an arithmetic right shift. Vacated high bits copy the operand's sign bit W-1. CF is operand bit n-1 for n at most W, and the sign bit for larger n.
- R5: Op code 3 rotates left and op code 4 rotates right, by n modulo W. CF equals result bit 0 after a left rotate and result bit W-1 after a right rotate, including when n is a nonzero multiple of W.
- R6: Op code 5 rotates left and op code 6 rotates right the (W+1)-bit ring {CF, operand} by n modulo W+1. The result is the low W bits of the ring and CF is its top bit.
- R7: A count of 0 returns the operand truncated to the selected size and leaves CF, SF and ZF equal to the incoming flags.
- R8: A shift (op codes 0, 1, 2, 7) with a nonzero count sets SF to result bit W-1 and ZF to 1 exactly when the result is zero.
- R9: The rotates (op codes 3 to 6) return SF and ZF equal to the incoming values.
- R10: Size code 0 selects W=8, code 1 selects W=16, and codes 2 and 3 select W=32. Operand bits at or above W have no effect, and result bits at or above W are zero.
- R11: While reset is asserted, and after it, until the first operation, `out_valid`, `out_res` and all three flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_opnd | input | 32 | Operand |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Size select |
| in_cnt | input | 5 | Shift or rotate count |
| in_cf | input | 1 | Incoming carry flag |
| in_sf | input | 1 | Incoming sign flag |
| in_zf | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result valid |
| out_res | output | 32 | Result, zero above the selected size |
| out_cf | output | 1 | Updated carry flag |
| out_sf | output | 1 | Updated sign flag |
| out_zf | output | 1 | Updated zero flag |

## Verification
The bench builds the unit with its default of three size lanes (8, 16 and 32 bits) and the 5-bit count. With those values a count can exceed the width of the two narrow lanes. That brings over-width shifts within reach, where the carry becomes zero or the sign bit. It also brings multi-turn rotates within reach, including the modulo-9 and modulo-17 wrap of the carry ring. Each case is compared against a reference that moves the operand one bit per step.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int NUM_SIZES = 3;
    localparam int MAX_W     = 8 << (NUM_SIZES - 1);
    localparam int CNT_W     = 5;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_SAL = 3'd7
    } shrot_op_e;

    typedef struct packed {
        logic             valid;
        logic [MAX_W-1:0] res;
        logic             cf;
        logic             sf;
        logic             zf;
    } shrot_stage_t;

    function automatic logic op_is_shift(input shrot_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR) || (op == OP_SAL);
    endfunction

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 5
) (
    input  logic [W-1:0]  opnd,
    input  shrot_op_e     op,
    input  logic [CW-1:0] cnt,
    input  logic          cf_in,
    output logic [W-1:0]  res,
    output logic          cf_out
);

    localparam int RING_W = W + 1;

    logic [2*W-1:0]      shl_t;
    logic [2*W-1:0]      shr_t;
    logic [2*W-1:0]      sar_t;
    logic [2*W-1:0]      rol_t;
    logic [2*W-1:0]      ror_t;
    logic [2*RING_W-1:0] rcl_t;
    logic [2*RING_W-1:0] rcr_t;
    logic [RING_W-1:0]   ring;
    logic [CW-1:0]       rot_amt;
    logic [CW:0]         ring_amt;

    // count reduction for the plain rotates (W is a power of two)
    always_comb begin
        rot_amt = cnt & CW'(W - 1);
    end

    // count reduction for the carry ring: repeated subtraction of W+1
    always_comb begin
        ring_amt = {1'b0, cnt};
        for (int k = 0; k < 4; k++) begin
            if (ring_amt >= (CW+1)'(RING_W)) begin
                ring_amt = ring_amt - (CW+1)'(RING_W);
            end
        end
    end

    always_comb begin
        ring  = {cf_in, opnd};
        shl_t = {{W{1'b0}}, opnd} << cnt;
        shr_t = {opnd, {W{1'b0}}} >> cnt;
        sar_t = $signed({opnd, {W{1'b0}}}) >>> cnt;
        rol_t = {opnd, opnd} << rot_amt;
        ror_t = {opnd, opnd} >> rot_amt;
        rcl_t = {ring, ring} << ring_amt;
        rcr_t = {ring, ring} >> ring_amt;
    end

    always_comb begin
        res    = opnd;
        cf_out = cf_in;
        unique case (op)
            OP_SHL, OP_SAL: begin
                res    = shl_t[W-1:0];
                cf_out = shl_t[W];
            end
            OP_SHR: begin
                res    = shr_t[2*W-1:W];
                cf_out = shr_t[W-1];
            end
            OP_SAR: begin
                res    = sar_t[2*W-1:W];
                cf_out = sar_t[W-1];
            end
            OP_ROL: begin
                res    = rol_t[2*W-1:W];
                cf_out = rol_t[W];
            end
            OP_ROR: begin
                res    = ror_t[W-1:0];
                cf_out = ror_t[W-1];
            end
            OP_RCL: begin
                res    = rcl_t[2*RING_W-2:RING_W];
                cf_out = rcl_t[2*RING_W-1];
            end
            OP_RCR: begin
                res    = rcr_t[W-1:0];
                cf_out = rcr_t[W];
            end
            default: begin
                res    = opnd;
                cf_out = cf_in;
            end
        endcase
    end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
    parameter int DATA_W    = 32,
    parameter int NUM_SIZES = 3
) (
    input  logic [DATA_W-1:0] res,
    input  logic [1:0]        size_idx,
    input  logic              is_shift,
    input  logic              cnt_zero,
    input  logic              op_cf,
    input  logic              cf_in,
    input  logic              sf_in,
    input  logic              zf_in,
    output logic              cf,
    output logic              sf,
    output logic              zf
);

    logic msb;

    always_comb begin
        msb = res[DATA_W-1];
        for (int g = 0; g < NUM_SIZES; g++) begin
            if (size_idx == 2'(g)) begin
                msb = res[(8 << g) - 1];
            end
        end
    end

    always_comb begin
        cf = cf_in;
        sf = sf_in;
        zf = zf_in;
        if (!cnt_zero) begin
            cf = op_cf;
            if (is_shift) begin
                sf = msb;
                zf = (res == '0);
            end
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int NUM_LANES = shrot_pkg::NUM_SIZES,
    parameter int CW        = shrot_pkg::CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [MAX_W-1:0]      in_opnd,
    input  logic [2:0]            in_op,
    input  logic [1:0]            in_size,
    input  logic [CW-1:0]         in_cnt,
    input  logic                  in_cf,
    input  logic                  in_sf,
    input  logic                  in_zf,
    output logic                  out_valid,
    output logic [MAX_W-1:0]      out_res,
    output logic                  out_cf,
    output logic                  out_sf,
    output logic                  out_zf
);

    localparam int DATA_W = 8 << (NUM_LANES - 1);

    shrot_op_e         op_e;
    logic [1:0]        size_idx;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_cf  [NUM_LANES];
    logic [DATA_W-1:0] sel_res;
    logic              sel_cf;
    logic              cnt_zero;
    logic              f_cf, f_sf, f_zf;
    shrot_stage_t      stage_d, stage_q;

    always_comb begin
        op_e     = shrot_op_e'(in_op);
        cnt_zero = (in_cnt == '0);
        size_idx = (in_size >= 2'(NUM_LANES)) ? 2'(NUM_LANES - 1) : in_size;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW-1:0] r_w;
        logic          c_w;

        shrot_lane #(
            .W  (LW),
            .CW (CW)
        ) u_lane (
            .opnd   (in_opnd[LW-1:0]),
            .op     (op_e),
            .cnt    (in_cnt),
            .cf_in  (in_cf),
            .res    (r_w),
            .cf_out (c_w)
        );

        assign lane_res[g] = DATA_W'(r_w);
        assign lane_cf[g]  = c_w;
    end

    always_comb begin
        sel_res = lane_res[size_idx];
        sel_cf  = lane_cf[size_idx];
    end

    shrot_flags #(
        .DATA_W    (DATA_W),
        .NUM_SIZES (NUM_LANES)
    ) u_flags (
        .res      (sel_res),
        .size_idx (size_idx),
        .is_shift (op_is_shift(op_e)),
        .cnt_zero (cnt_zero),
        .op_cf    (sel_cf),
        .cf_in    (in_cf),
        .sf_in    (in_sf),
        .zf_in    (in_zf),
        .cf       (f_cf),
        .sf       (f_sf),
        .zf       (f_zf)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.res = sel_res;
            stage_d.cf  = f_cf;
            stage_d.sf  = f_sf;
            stage_d.zf  = f_zf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_res   = stage_q.res;
    assign out_cf    = stage_q.cf;
    assign out_sf    = stage_q.sf;
    assign out_zf    = stage_q.zf;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
    import shrot_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [1:0]       in_size,
    input logic [CNT_W-1:0] in_cnt,
    input logic             in_cf,
    input logic             in_sf,
    input logic             in_zf,
    input logic             out_valid,
    input logic [MAX_W-1:0] out_res,
    input logic             out_cf,
    input logic             out_sf,
    input logic             out_zf
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_res) && $stable(out_cf) && $stable(out_sf) && $stable(out_zf)));

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_cnt) == '0) |->
        (out_cf == $past(in_cf) && out_sf == $past(in_sf) && out_zf == $past(in_zf)));

    p_rotate_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) >= 3'd3 && $past(in_op) <= 3'd6) |->
        (out_sf == $past(in_sf) && out_zf == $past(in_zf)));

    p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_size) == 2'd0) |-> (out_res[MAX_W-1:8] == '0));

    p_ror_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == 3'd4 && $past(in_size) >= 2'd2 && $past(in_cnt) != '0) |->
        (out_cf == out_res[MAX_W-1]));

    p_shift_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_cnt) != '0 &&
         ($past(in_op) <= 3'd2 || $past(in_op) == 3'd7)) |->
        (out_zf == (out_res == '0)));

endmodule

bind shrot_unit shrot_unit_chk u_chk (.*);

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_opnd = '0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [4:0]  in_cnt = '0;
    logic        in_cf = 1'b0, in_sf = 1'b0, in_zf = 1'b0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_cf, out_sf, out_zf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_op(in_op), .in_size(in_size), .in_cnt(in_cnt), .in_cf(in_cf),
        .in_sf(in_sf), .in_zf(in_zf), .out_valid(out_valid), .out_res(out_res),
        .out_cf(out_cf), .out_sf(out_sf), .out_zf(out_zf)
    );

    // bit-serial reference model
    task automatic ref_op(input logic [31:0] opnd, input int op, input int sz, input int cnt,
                          input logic cfi, input logic sfi, input logic zfi,
                          output logic [31:0] r, output logic cf, output logic sf, output logic zf);
        int w;
        logic [31:0] mask, v;
        logic c, b;
        w = (sz >= 2) ? 32 : (8 << sz);
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        v = opnd & mask;
        c = cfi;
        for (int k = 0; k < cnt; k++) begin
            case (op)
                0, 7: begin c = v[w-1]; v = (v << 1) & mask; end
                1: begin c = v[0]; v = v >> 1; end
                2: begin b = v[w-1]; c = v[0]; v = (v >> 1) | ({31'd0, b} << (w-1)); end
                3: begin c = v[w-1]; v = ((v << 1) | {31'd0, c}) & mask; end
                4: begin c = v[0]; v = (v >> 1) | ({31'd0, c} << (w-1)); end
                5: begin b = v[w-1]; v = ((v << 1) | {31'd0, c}) & mask; c = b; end
                default: begin b = v[0]; v = (v >> 1) | ({31'd0, c} << (w-1)); c = b; end
            endcase
        end
        r = v; cf = c; sf = sfi; zf = zfi;
        if (cnt != 0 && (op <= 2 || op == 7)) begin
            sf = v[w-1];
            zf = (v == 32'd0);
        end
    endtask

    function automatic string op_tag(input int op, input int cnt);
        if (cnt == 0) return "R7";
        case (op)
            0, 7: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] opnd, input int op, input int sz, input int cnt,
                       input logic cfi, input logic sfi, input logic zfi);
        logic [31:0] er;
        logic ec, es, ez;
        @(negedge clk);
        in_valid = 1'b1; in_opnd = opnd; in_op = 3'(op); in_size = 2'(sz);
        in_cnt = 5'(cnt); in_cf = cfi; in_sf = sfi; in_zf = zfi;
        @(negedge clk);
        in_valid = 1'b0;
        ref_op(opnd, op, sz, cnt, cfi, sfi, zfi, er, ec, es, ez);
        check(out_valid == 1'b1, "R1", {35'd0, out_valid}, 36'd1);
        check(out_res == er && out_cf == ec, op_tag(op, cnt),
              {3'd0, out_cf, out_res}, {3'd0, ec, er});
        check(out_sf == es && out_zf == ez,
              (cnt == 0) ? "R7" : ((op <= 2 || op == 7) ? "R8" : "R9"),
              {34'd0, out_sf, out_zf}, {34'd0, es, ez});
        if (sz < 2) begin
            // R10: upper bits zero whatever the operand held above the size
            check((out_res >> (8 << sz)) == 32'd0, "R10", {4'd0, out_res}, {4'd0, er});
        end
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_res == 0 && !out_cf && !out_sf && !out_zf, "R11",
              {3'd0, out_valid, out_res}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_res == 0 && !out_cf && !out_sf && !out_zf, "R11",
              {3'd0, out_valid, out_res}, 36'd0);

        // directed corners
        run(32'hFFFF_FF81, 0, 0, 1, 0, 0, 0);   // R2 byte shl, carry out of bit 7
        run(32'h0000_0081, 7, 0, 8, 0, 0, 0);   // R2 count equals width
        run(32'h0000_00FF, 0, 0, 9, 1, 0, 0);   // R2 count past width
        run(32'h0000_8001, 1, 1, 16, 0, 0, 0);  // R3 count equals width
        run(32'h0000_8000, 2, 1, 20, 0, 0, 0);  // R4 past width, sign fill
        run(32'h8000_0001, 2, 2, 31, 0, 0, 1);  // R4
        run(32'h0000_0081, 3, 0, 16, 0, 1, 1);  // R5 multiple of width
        run(32'h1234_5678, 4, 2, 4, 0, 0, 0);   // R5
        run(32'h0000_00A5, 5, 0, 9, 1, 1, 0);   // R6 full ring turn
        run(32'h0000_00A5, 6, 0, 10, 1, 0, 1);  // R6 wrap modulo 9
        run(32'h0000_F00F, 5, 1, 18, 0, 0, 0);  // R6 wrap modulo 17
        run(32'h8000_0001, 6, 3, 31, 1, 0, 0);  // R6 size code 3
        for (int op = 0; op < 8; op++) begin
            run(32'hDEAD_BEEF, op, op % 3, 0, 1, 1, 0); // R7
        end
        run(32'h0000_0080, 1, 0, 8, 0, 1, 0);   // R8 zero result sets ZF

        // R1 hold while idle
        held = out_res;
        @(negedge clk);
        in_opnd = 32'h0F0F_0F0F; in_op = 3'd3; in_cnt = 5'd7;
        @(negedge clk);
        check(out_valid == 0 && out_res == held, "R1", {3'd0, out_valid, out_res}, {4'd0, held});

        // constrained random
        for (int i = 0; i < 600; i++) begin
            int c;
            c = ($urandom % 5 == 0) ? 0 : int'($urandom % 32);
            run($urandom, int'($urandom % 8), int'($urandom % 4), c,
                1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule